// File: doc/BRIEF.md
# Internal Oscillator Enable Controller

This block sits on the register side of an on-chip RC oscillator. It holds the software enable bit and a 5-bit user trim field, and it publishes a ready flag. It adds the user trim to a factory calibration code and saturates the result, so the analog side always receives a usable trim code. It also applies the hardware rules that stop the oscillator from being switched off while the system clock depends on it, and that turn it on whenever the chip needs it as a fallback.

The block runs on the clock derived from the internal oscillator, so its cycle counts are oscillator cycles. The analog side reports that the oscillator is stable through an asynchronous `stable_in` level, which passes through a two-stage synchronizer. The ready flag comes from a three-state machine:

- `RDY_OFF`: ready low. It moves to `RDY_ON` when the enable bit is 1 and the synchronized stable level is high.
- `RDY_ON`: ready high. It moves to `RDY_DRAIN` when the enable bit is seen low; the drain counter is loaded with 1.
- `RDY_DRAIN`: ready high while the counter advances. It returns to `RDY_ON` when the enable bit is seen high again. It moves to `RDY_OFF` when the counter reaches `DROP_CYC-1`.

The control word is laid out as follows: bits 7:3 hold the trim, bit 2 is reserved, bit 1 is the ready flag and bit 0 is the enable. The system-clock source selections use this encoding: 2'b00 internal RC, 2'b01 external oscillator, 2'b10 PLL, 2'b11 none. When the PLL is selected, `pll_on_ext` tells which oscillator feeds it: 1 for the external oscillator, 0 for the internal one.

Top module: `rcosc_enable_ctrl`

## Requirements
- R1: While reset is held, the enable is 0, the trim is 16, the ready flag is 0 and `osc_on` is 0, so `ctrl_rd` reads 8'h80.
- R2: A write loads the trim from bits 7:3 and the enable from bit 0. Bits 2 and 1 of the written word are ignored. Bit 2 always reads 0, and bit 1 always reads the ready flag.
- R3: A pulse on `lp_exit` sets the enable at the next edge, even when a write of 0 to the enable arrives in the same cycle.
- R4: A pulse on `ext_fail` sets the enable only while the external oscillator drives the current system clock. This covers direct selection (2'b01) and the PLL fed from the external oscillator (2'b10 with `pll_on_ext`=1). In every other case the pulse has no effect.
- R5: A write of 0 to the enable is ignored while the current source uses the internal oscillator: either 2'b00, or 2'b10 with `pll_on_ext`=0.
- R6: A write of 0 to the enable is ignored while the pending source selection uses the internal oscillator, with the same decode as R5.
- R7: The ready flag rises only while the enable is 1 and the synchronized stable level is high. With the enable already 1, it rises at the third edge after `stable_in` goes high. With `stable_in` already settled high, it rises one edge after the enable is set.
- R8: When the enable is cleared at edge E, the ready flag stays high through edge E+5 and falls at edge E+6, for the default `DROP_CYC`=6.
- R9: Setting the enable again while the ready flag is draining keeps the flag high. A later clear then counts a full `DROP_CYC` again.
- R10: `trim_code` equals `cal_code` plus the trim, clamped to 8'hFF instead of wrapping.
- R11: `osc_on` is high whenever the enable is 1 or the ready flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wd | input | 8 | Control word write data |
| ctrl_rd | output | 8 | Control word read data |
| cal_code | input | 8 | Factory calibration code |
| lp_exit | input | 1 | One-cycle pulse on exit from a low-power mode |
| ext_fail | input | 1 | One-cycle pulse on external oscillator failure |
| sys_src_cur | input | 2 | Current system-clock source |
| sys_src_req | input | 2 | Pending system-clock source |
| pll_on_ext | input | 1 | PLL reference is the external oscillator |
| stable_in | input | 1 | Asynchronous stable level from the analog oscillator |
| osc_on | output | 1 | Request to run the oscillator |
| rdy | output | 1 | Ready flag |
| trim_code | output | 8 | Saturated effective trim code |

## Verification
The assertions assume three things about the inputs. `lp_exit`, `ext_fail`, the source selections and `pll_on_ext` are synchronous to `clk`. `cal_code` is a static level. `stable_in` is the only asynchronous input. The bench keeps to these assumptions: it changes every input on the falling edge, holds each pulse for exactly one cycle, and moves `stable_in` only through the synchronizer path. This means the cycle counts in R7 and R8 are measured from known edges.

// File: rtl/rcosc_pkg.sv
package rcosc_pkg;

    typedef enum logic [1:0] {
        RDY_OFF   = 2'b00,
        RDY_ON    = 2'b01,
        RDY_DRAIN = 2'b10
    } rdy_state_e;

    localparam logic [1:0] SRC_INT = 2'b00;
    localparam logic [1:0] SRC_EXT = 2'b01;
    localparam logic [1:0] SRC_PLL = 2'b10;

    // Selection depends on the internal RC, directly or through the PLL.
    function automatic logic src_needs_int(input logic [1:0] sel, input logic pll_ext);
        return (sel == SRC_INT) || ((sel == SRC_PLL) && !pll_ext);
    endfunction

    // Selection depends on the external oscillator, directly or through the PLL.
    function automatic logic src_needs_ext(input logic [1:0] sel, input logic pll_ext);
        return (sel == SRC_EXT) || ((sel == SRC_PLL) && pll_ext);
    endfunction

endpackage

// File: rtl/rcosc_sync.sv
module rcosc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else if (g == 0) begin
                    chain[g] <= d_i;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rcosc_trim_sum.sv
module rcosc_trim_sum #(
    parameter int TRIM_W = 5,
    parameter int CAL_W  = 8
) (
    input  logic [TRIM_W-1:0] trim_i,
    input  logic [CAL_W-1:0]  cal_i,
    output logic [CAL_W-1:0]  code_o
);
    localparam int SUM_W = CAL_W + 1;
    logic [SUM_W-1:0] raw;

    always_comb begin
        raw = SUM_W'(cal_i) + SUM_W'(trim_i);
        if (raw[CAL_W]) begin
            code_o = '1;
        end else begin
            code_o = raw[CAL_W-1:0];
        end
    end
endmodule

// File: rtl/rcosc_ready_fsm.sv
module rcosc_ready_fsm
    import rcosc_pkg::*;
#(
    parameter int DROP_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic stable_i,
    output logic ready_o
);
    localparam int CNT_W = $clog2(DROP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DROP_CYC - 1);

    rdy_state_e       st, nxt;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        nxt = st;
        unique case (st)
            RDY_OFF:   if (en_i && stable_i) nxt = RDY_ON;
            RDY_ON:    if (!en_i) nxt = RDY_DRAIN;
            RDY_DRAIN: begin
                if (en_i)                 nxt = RDY_ON;
                else if (cnt == CNT_LAST) nxt = RDY_OFF;
            end
            default:   nxt = RDY_OFF;
        endcase
    end

    // State register and drain counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= RDY_OFF;
            cnt <= '0;
        end else begin
            st <= nxt;
            if (st != RDY_DRAIN) begin
                cnt <= CNT_W'(1);
            end else if (cnt != CNT_LAST) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        ready_o = (st != RDY_OFF);
    end

    // R7: a rising ready flag needs enable and synchronized stable in the prior cycle
    a_r7_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(en_i) && $past(stable_i)));

    // R8: the flag only falls after a cycle with the enable low
    a_r8_fall_only_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> !$past(en_i));

    // R8: drain counter stays inside its window
    a_r8_drain_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RDY_DRAIN) |-> (cnt <= CNT_LAST));

    // R9: re-enable while draining returns to ON with the flag high
    a_r9_reenable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RDY_DRAIN && en_i) |=> (ready_o && st == RDY_ON));
endmodule

// File: rtl/rcosc_enable_ctrl.sv
module rcosc_enable_ctrl
    import rcosc_pkg::*;
#(
    parameter int                TRIM_W   = 5,
    parameter int                CAL_W    = 8,
    parameter int                DROP_CYC = 6,
    parameter int                SYNC_N   = 2,
    parameter logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(16)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [TRIM_W+2:0] ctrl_wd,
    output logic [TRIM_W+2:0] ctrl_rd,
    input  logic [CAL_W-1:0]  cal_code,
    input  logic              lp_exit,
    input  logic              ext_fail,
    input  logic [1:0]        sys_src_cur,
    input  logic [1:0]        sys_src_req,
    input  logic              pll_on_ext,
    input  logic              stable_in,
    output logic              osc_on,
    output logic              rdy,
    output logic [CAL_W-1:0]  trim_code
);
    localparam int TRIM_LSB = 3;

    logic              en_q;
    logic [TRIM_W-1:0] trim_q;
    logic              stable_s;
    logic              hw_force;
    logic              int_locked;
    logic              ext_in_use;

    always_comb begin
        ext_in_use = src_needs_ext(sys_src_cur, pll_on_ext);
        int_locked = src_needs_int(sys_src_cur, pll_on_ext) ||
                     src_needs_int(sys_src_req, pll_on_ext);
        hw_force   = lp_exit || (ext_fail && ext_in_use);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            trim_q <= TRIM_RST;
        end else begin
            if (ctrl_we) begin
                trim_q <= ctrl_wd[TRIM_LSB +: TRIM_W];
            end
            if (hw_force) begin
                en_q <= 1'b1;
            end else if (ctrl_we) begin
                if (ctrl_wd[0])       en_q <= 1'b1;
                else if (!int_locked) en_q <= 1'b0;
            end
        end
    end

    rcosc_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (stable_in),
        .q_o   (stable_s)
    );

    rcosc_ready_fsm #(.DROP_CYC(DROP_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_q),
        .stable_i (stable_s),
        .ready_o  (rdy)
    );

    rcosc_trim_sum #(.TRIM_W(TRIM_W), .CAL_W(CAL_W)) u_sum (
        .trim_i (trim_q),
        .cal_i  (cal_code),
        .code_o (trim_code)
    );

    always_comb begin
        osc_on  = en_q || rdy;
        ctrl_rd = {trim_q, 1'b0, rdy, en_q};
    end

    // R3: low-power exit always leaves the enable set
    a_r3_lpexit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        lp_exit |=> en_q);

    // R4: external failure while it feeds the system clock sets the enable
    a_r4_extfail_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_fail && src_needs_ext(sys_src_cur, pll_on_ext)) |=> en_q);

    // R5: enable cannot drop while the current clock uses the internal RC
    a_r5_cur_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && src_needs_int(sys_src_cur, pll_on_ext)) |=> en_q);

    // R6: enable cannot drop while the pending selection uses the internal RC
    a_r6_req_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && src_needs_int(sys_src_req, pll_on_ext)) |=> en_q);

    // R10: effective code never wraps below the calibration value
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        trim_code >= cal_code);
endmodule

// File: tb/rcosc_enable_ctrl_tb.sv
module rcosc_enable_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wd = 8'h00;
    logic [7:0] ctrl_rd;
    logic [7:0] cal_code = 8'h40;
    logic       lp_exit = 1'b0;
    logic       ext_fail = 1'b0;
    logic [1:0] sys_src_cur = 2'b01;
    logic [1:0] sys_src_req = 2'b01;
    logic       pll_on_ext = 1'b0;
    logic       stable_in = 1'b0;
    logic       osc_on;
    logic       rdy;
    logic [7:0] trim_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    rcosc_enable_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
        .ctrl_rd(ctrl_rd), .cal_code(cal_code), .lp_exit(lp_exit),
        .ext_fail(ext_fail), .sys_src_cur(sys_src_cur), .sys_src_req(sys_src_req),
        .pll_on_ext(pll_on_ext), .stable_in(stable_in), .osc_on(osc_on),
        .rdy(rdy), .trim_code(trim_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wd = d;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rd", 32'(ctrl_rd), 32'h80);
        chk("R1 rdy", 32'(rdy), 0);
        chk("R1 osc_on", 32'(osc_on), 0);
        chk("R1 trim_code", 32'(trim_code), 32'h50);
    endtask

    task automatic t_write;
        wr(8'hAF);
        chk("R2 rd after write", 32'(ctrl_rd), 32'hA9);
        chk("R10 sum", 32'(trim_code), 32'h55);
        chk("R11 osc_on enable", 32'(osc_on), 1);
        wr(8'hA8);
        chk("R2 rd after clear", 32'(ctrl_rd), 32'hA8);
        chk("R11 osc_on off", 32'(osc_on), 0);
    endtask

    task automatic t_ready_rise;
        stable_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 no ready without enable", 32'(rdy), 0);
        wr(8'hA9);
        chk("R7 ready not yet", 32'(rdy), 0);
        @(negedge clk);
        chk("R7 ready one edge after enable", 32'(rdy), 1);
        chk("R2 bit1 reads ready", 32'(ctrl_rd), 32'hAB);
        stable_in = 1'b0;
        wr(8'hA8);
        repeat (8) @(negedge clk);
        wr(8'hA9);
        repeat (3) @(negedge clk);
        chk("R7 ready waits stable", 32'(rdy), 0);
        stable_in = 1'b1;
        @(negedge clk);
        chk("R7 sync edge1", 32'(rdy), 0);
        @(negedge clk);
        chk("R7 sync edge2", 32'(rdy), 0);
        @(negedge clk);
        chk("R7 sync edge3", 32'(rdy), 1);
    endtask

    task automatic t_drop;
        wr(8'hA8);
        chk("R8 held at clear edge", 32'(rdy), 1);
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            chk("R8 held during drain", 32'(rdy), 1);
            chk("R11 osc_on during drain", 32'(osc_on), 1);
        end
        @(negedge clk);
        chk("R8 falls at sixth edge", 32'(rdy), 0);
        chk("R11 osc_on after drain", 32'(osc_on), 0);
    endtask

    task automatic t_reenable;
        wr(8'hA9);
        @(negedge clk);
        chk("R9 ready up", 32'(rdy), 1);
        wr(8'hA8);
        repeat (2) @(negedge clk);
        wr(8'hA9);
        chk("R9 held on re-enable", 32'(rdy), 1);
        @(negedge clk);
        chk("R9 held after re-enable", 32'(rdy), 1);
        repeat (2) @(negedge clk);
        wr(8'hA8);
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            chk("R9 full window again", 32'(rdy), 1);
        end
        @(negedge clk);
        chk("R9 falls after full window", 32'(rdy), 0);
    endtask

    task automatic t_lpexit;
        @(negedge clk);
        lp_exit = 1'b1;
        ctrl_we = 1'b1;
        ctrl_wd = 8'hA8;
        @(negedge clk);
        lp_exit = 1'b0;
        ctrl_we = 1'b0;
        chk("R3 lp exit beats write", 32'(ctrl_rd[0]), 1);
        wr(8'hA8);
        chk("R3 clear after", 32'(ctrl_rd[0]), 0);
    endtask

    task automatic pulse_fail;
        @(negedge clk);
        ext_fail = 1'b1;
        @(negedge clk);
        ext_fail = 1'b0;
    endtask

    task automatic t_extfail;
        sys_src_cur = 2'b01;
        pulse_fail();
        chk("R4 direct external", 32'(ctrl_rd[0]), 1);
        wr(8'hA8);
        sys_src_cur = 2'b10;
        pll_on_ext = 1'b1;
        pulse_fail();
        chk("R4 PLL on external", 32'(ctrl_rd[0]), 1);
        wr(8'hA8);
        chk("R4 cleared", 32'(ctrl_rd[0]), 0);
        pll_on_ext = 1'b0;
        pulse_fail();
        chk("R4 PLL on internal ignored", 32'(ctrl_rd[0]), 0);
        sys_src_cur = 2'b11;
        pulse_fail();
        chk("R4 no source ignored", 32'(ctrl_rd[0]), 0);
    endtask

    task automatic t_lock;
        sys_src_cur = 2'b00;
        wr(8'hA9);
        wr(8'hA8);
        chk("R5 internal direct holds", 32'(ctrl_rd[0]), 1);
        sys_src_cur = 2'b10;
        pll_on_ext = 1'b0;
        wr(8'hA8);
        chk("R5 PLL on internal holds", 32'(ctrl_rd[0]), 1);
        pll_on_ext = 1'b1;
        wr(8'hA8);
        chk("R5 PLL on external clears", 32'(ctrl_rd[0]), 0);
        sys_src_cur = 2'b01;
        sys_src_req = 2'b00;
        wr(8'hA9);
        wr(8'hA8);
        chk("R6 pending internal holds", 32'(ctrl_rd[0]), 1);
        sys_src_req = 2'b10;
        pll_on_ext = 1'b0;
        wr(8'hA8);
        chk("R6 pending PLL internal holds", 32'(ctrl_rd[0]), 1);
        sys_src_req = 2'b01;
        wr(8'hA8);
        chk("R6 pending external clears", 32'(ctrl_rd[0]), 0);
    endtask

    task automatic t_trim;
        cal_code = 8'hF0;
        wr(8'hF8);
        chk("R10 saturate high", 32'(trim_code), 32'hFF);
        cal_code = 8'hE0;
        #1 chk("R10 exact max", 32'(trim_code), 32'hFF);
        cal_code = 8'hE1;
        #1 chk("R10 one over", 32'(trim_code), 32'hFF);
        cal_code = 8'h12;
        wr(8'h18);
        chk("R10 plain sum", 32'(trim_code), 32'h15);
        cal_code = 8'h00;
        wr(8'h00);
        chk("R10 zero", 32'(trim_code), 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write();
        t_ready_rise();
        t_drop();
        t_reenable();
        t_lpexit();
        t_extfail();
        t_lock();
        t_trim();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule